// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the register-transfer half of a 32-bit load/store processor that spends several clock cycles on each instruction. It holds the program counter, the instruction word, a latch for data read from memory, two operand latches filled from the register file, and a latch that keeps the previous ALU result. It also contains a 32-entry register file, the ALU, the immediate sign extender and shifters, and every steering multiplexer. A single memory port carries both instruction fetches and data loads and stores.

The block makes no decisions. Each select, enable and ALU operation code comes in as a plain input from a separate sequencing controller. The block returns the instruction's 6-bit operation field and the ALU zero flag so that the controller can choose its next step. Memory sits outside the block. It answers a read in the same cycle and commits a write at the clock edge, under the controller's own write strobe. Memory can never stall the block, so the memory port has no valid/ready handshake and no back-pressure. Every pin is a plain level.

Instruction fields follow the usual layout: operation in bits 31..26, first source register in 25..21, second source or load target in 20..16, R-type destination in 15..11, immediate in 15..0, and jump index in 25..0.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the program counter, instruction latch, memory-data latch, both operand latches, the result latch and every register are cleared. After reset, with `addr_sel`=0, `mem_addr` reads 0 and `mem_wdata` reads 0.
- R2: `mem_addr` shows the program counter when `addr_sel` is 0 and the ALU result latch when `addr_sel` is 1.
- R3: The first ALU input is the program counter when `srca_sel`=0 and the first operand latch when `srca_sel`=1. The second input depends on `srcb_sel`: 0 selects the second operand latch, 1 the constant 4, 2 the sign-extended immediate, and 3 that immediate shifted left by two.
- R4: `alu_op` codes: 3'b000 AND, 3'b001 OR, 3'b010 add, 3'b110 subtract, 3'b111 signed set-less-than (result 1 or 0). `alu_zero` is 1 exactly when the current ALU result is zero.
- R5: The program counter loads at a clock edge when `pc_wr`=1, or when `pc_wr_cond`=1 and `alu_zero`=1. Otherwise it keeps its value.
- R6: `pc_src` picks the next program counter value: 0 the live ALU result, 1 the ALU result latch, 2 the jump target. The jump target is the top 4 bits of the program counter, then instruction bits 25..0, then two zero bits.
- R7: The instruction latch loads `mem_rdata` only at edges where `ir_load`=1. `opcode` is bits 31..26 of the latched instruction.
- R8: The operand latches load every edge from registers addressed by instruction bits 25..21 and 20..16. With `rf_we`=1, the register named by bits 20..16 (`dst_sel`=0) or 15..11 (`dst_sel`=1) is written. The data is the result latch when `wb_sel`=0 and the memory-data latch when `wb_sel`=1.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: When a register is written at the same edge at which an operand latch reads it, the latch takes the old value. The new value appears one edge later.
- R11: The memory-data latch and the ALU result latch load at every edge. `mem_wdata` always shows the second operand latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_cond | input | 1 | Program counter write gated by the zero flag |
| ir_load | input | 1 | Load the instruction latch from memory |
| addr_sel | input | 1 | Memory address source: 0 program counter, 1 result latch |
| srca_sel | input | 1 | First ALU input: 0 program counter, 1 operand latch A |
| srcb_sel | input | 2 | Second ALU input select |
| alu_op | input | 3 | ALU operation code |
| pc_src | input | 2 | Next program counter source |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Write address: 0 bits 20..16, 1 bits 15..11 |
| wb_sel | input | 1 | Write data: 0 result latch, 1 memory-data latch |
| mem_rdata | input | 32 | Memory read data for the current address |
| mem_addr | output | 32 | Shared memory byte address |
| mem_wdata | output | 32 | Store data (second operand latch) |
| opcode | output | 6 | Operation field of the latched instruction |
| alu_zero | output | 1 | Current ALU result equals zero |

## Verification
A register write-back and an operand latch load can happen at the same clock edge on the same register. That happens at the last step of a load whose target is also the second source field of the instruction still held in the latch. The bench runs a word load into a fresh register and reads `mem_wdata` in the next two cycles. It expects the stale value (zero) first and the loaded word one cycle later. Instruction fetch also puts two actions on one edge: the program counter advances while the instruction latch captures the word at the old address. The bench judges this from the address and operation field it sees after each fetch.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam int OPC_LSB  = 26;
  localparam int OPC_W    = 6;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int PCHI_W   = 4;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG   = 2'd0,
    SRCB_FOUR  = 2'd1,
    SRCB_IMM   = 2'd2,
    SRCB_IMMSH = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCS_ALU  = 2'd0,
    PCS_LAT  = 2'd1,
    PCS_JUMP = 2'd2,
    PCS_RSVD = 2'd3
  } pcsrc_e;

endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [2:0]      op,
  output logic [XLEN-1:0] res,
  output logic            zero
);

  logic [XLEN-1:0] diff;
  logic            lt_signed;

  assign diff = opa - opb;

  // signed compare from sign bits and the difference
  always_comb begin
    if (opa[XLEN-1] != opb[XLEN-1]) lt_signed = opa[XLEN-1];
    else                            lt_signed = diff[XLEN-1];
  end

  always_comb begin
    unique case (alu_op_e'(op))
      ALU_AND: res = opa & opb;
      ALU_OR:  res = opa | opb;
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = diff;
      ALU_SLT: res = {{(XLEN-1){1'b0}}, lt_signed};
      default: res = '0;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra_a,
  input  logic [$clog2(NREG)-1:0] ra_b,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [XLEN-1:0]         wd,
  output logic [XLEN-1:0]         rd_a,
  output logic [XLEN-1:0]         rd_b
);

  logic [XLEN-1:0] word [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign word[g] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     q <= '0;
        else if (we && (wa == g[$clog2(NREG)-1:0])) q <= wd;
      end
      assign word[g] = q;
    end
  end

  assign rd_a = word[ra_a];
  assign rd_b = word[ra_b];

endmodule

// File: rtl/mcd_pc_unit.sv
module mcd_pc_unit
  import mcd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic              zero,
  input  logic [1:0]        pc_src,
  input  logic [XLEN-1:0]   alu_res,
  input  logic [XLEN-1:0]   alu_lat,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   pc_q
);

  localparam int JPAD = XLEN - PCHI_W - JIDX_W;

  logic [XLEN-1:0] jump_tgt;
  logic [XLEN-1:0] pc_next;
  logic            pc_en;

  assign jump_tgt = {pc_q[XLEN-1 -: PCHI_W], jidx, {JPAD{1'b0}}};
  assign pc_en    = pc_wr | (pc_wr_cond & zero);

  always_comb begin
    unique case (pcsrc_e'(pc_src))
      PCS_ALU:  pc_next = alu_res;
      PCS_LAT:  pc_next = alu_lat;
      PCS_JUMP: pc_next = jump_tgt;
      default:  pc_next = alu_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_next;
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_wr,
  input  logic             pc_wr_cond,
  input  logic             ir_load,
  input  logic             addr_sel,
  input  logic             srca_sel,
  input  logic [1:0]       srcb_sel,
  input  logic [2:0]       alu_op,
  input  logic [1:0]       pc_src,
  input  logic             rf_we,
  input  logic             dst_sel,
  input  logic             wb_sel,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic [OPC_W-1:0] opcode,
  output logic             alu_zero
);

  localparam int AW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] rf_rd_a, rf_rd_b, wr_data;
  logic [XLEN-1:0] alu_a, alu_b, alu_res;
  logic [XLEN-1:0] imm_sext, imm_shl;
  logic [AW-1:0]   wr_addr;

  // operand latches and data latches: loaded every edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      mdr_q    <= mem_rdata;
      a_q      <= rf_rd_a;
      b_q      <= rf_rd_b;
      aluout_q <= alu_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir_q <= '0;
    else if (ir_load) ir_q <= mem_rdata;
  end

  assign imm_sext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_shl  = {imm_sext[XLEN-3:0], 2'b00};

  assign alu_a = srca_sel ? a_q : pc_q;

  always_comb begin
    unique case (srcb_e'(srcb_sel))
      SRCB_REG:   alu_b = b_q;
      SRCB_FOUR:  alu_b = XLEN'(4);
      SRCB_IMM:   alu_b = imm_sext;
      SRCB_IMMSH: alu_b = imm_shl;
      default:    alu_b = b_q;
    endcase
  end

  assign wr_addr = dst_sel ? ir_q[RD_LSB +: AW] : ir_q[RT_LSB +: AW];
  assign wr_data = wb_sel  ? mdr_q : aluout_q;

  mcd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk  (clk),
    .rst_n(rst_n),
    .ra_a (ir_q[RS_LSB +: AW]),
    .ra_b (ir_q[RT_LSB +: AW]),
    .we   (rf_we),
    .wa   (wr_addr),
    .wd   (wr_data),
    .rd_a (rf_rd_a),
    .rd_b (rf_rd_b)
  );

  mcd_alu #(.XLEN(XLEN)) u_alu (
    .opa (alu_a),
    .opb (alu_b),
    .op  (alu_op),
    .res (alu_res),
    .zero(alu_zero)
  );

  mcd_pc_unit #(.XLEN(XLEN)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_wr     (pc_wr),
    .pc_wr_cond(pc_wr_cond),
    .zero      (alu_zero),
    .pc_src    (pc_src),
    .alu_res   (alu_res),
    .alu_lat   (aluout_q),
    .jidx      (ir_q[JIDX_W-1:0]),
    .pc_q      (pc_q)
  );

  assign mem_addr  = addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[OPC_LSB +: OPC_W];

endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pc_wr,
  input logic        pc_wr_cond,
  input logic        alu_zero,
  input logic [1:0]  pc_src,
  input logic        ir_load,
  input logic [31:0] mem_rdata,
  input logic [31:0] pc_q,
  input logic [31:0] ir_q,
  input logic [31:0] a_q,
  input logic [31:0] alu_res
);

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_q)); // R5

  AST_PC_FROM_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'd0) |=> (pc_q == $past(alu_res))); // R6

  AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'd2) |=> (pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00})); // R6

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir_q)); // R7

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (ir_q == $past(mem_rdata))); // R7

  AST_REG0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |=> (a_q == 32'd0)); // R9

endmodule

bind mc_datapath mcd_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc_wr     (pc_wr),
  .pc_wr_cond(pc_wr_cond),
  .alu_zero  (alu_zero),
  .pc_src    (pc_src),
  .ir_load   (ir_load),
  .mem_rdata (mem_rdata),
  .pc_q      (pc_q),
  .ir_q      (ir_q),
  .a_q       (a_q),
  .alu_res   (alu_res)
);

// File: tb/mc_datapath_tb_top.sv
`timescale 1ns/1ps
module mc_datapath_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        pc_wr, pc_wr_cond, ir_load, addr_sel, srca_sel;
  logic [1:0]  srcb_sel, pc_src;
  logic [2:0]  alu_op;
  logic        rf_we, dst_sel, wb_sel, mem_we;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode;
  logic        alu_zero;

  mc_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .ir_load(ir_load), .addr_sel(addr_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_src(pc_src), .rf_we(rf_we),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode),
    .alu_zero(alu_zero)
  );

  // memory model: same-cycle read, edge write
  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[7:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;

  typedef struct packed {
    logic       pc_wr, pc_wr_cond, ir_load, addr_sel, srca_sel;
    logic [1:0] srcb, pc_src;
    logic [2:0] alu;
    logic       rf_we, dst_sel, wb_sel, mem_we;
  } ctl_t;

  typedef struct {
    string       req;
    bit [3:0]    mask;   // 0 addr, 1 wdata, 2 opcode, 3 zero
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [5:0]  op;
    logic        zero;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic exp_t ex(string r, bit [3:0] m, logic [31:0] a,
                              logic [31:0] w, logic [5:0] o, logic z);
    exp_t e; e.req = r; e.mask = m; e.addr = a; e.wdata = w; e.op = o; e.zero = z;
    return e;
  endfunction

  function automatic exp_t none();
    return ex("", 4'b0, 0, 0, 0, 0);
  endfunction

  task automatic check(string r, string f, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, f, act, expv);
    end
  endtask

  // monitor: pops expectations and compares away from the edge
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (e.mask[0]) check(e.req, "mem_addr",  mem_addr,  e.addr);
      if (e.mask[1]) check(e.req, "mem_wdata", mem_wdata, e.wdata);
      if (e.mask[2]) check(e.req, "opcode",    {26'd0, opcode},   {26'd0, e.op});
      if (e.mask[3]) check(e.req, "alu_zero",  {31'd0, alu_zero}, {31'd0, e.zero});
    end
  end

  // driver: applies one control word per cycle and queues its expectation
  task automatic step(ctl_t c, exp_t e);
    @(negedge clk);
    pc_wr = c.pc_wr; pc_wr_cond = c.pc_wr_cond; ir_load = c.ir_load;
    addr_sel = c.addr_sel; srca_sel = c.srca_sel; srcb_sel = c.srcb;
    pc_src = c.pc_src; alu_op = c.alu; rf_we = c.rf_we; dst_sel = c.dst_sel;
    wb_sel = c.wb_sel; mem_we = c.mem_we;
    if (e.mask != 0) exp_q.push_back(e);
  endtask

  function automatic ctl_t c_idle(); ctl_t c = '0; return c; endfunction
  function automatic ctl_t c_fetch();
    ctl_t c = '0; c.pc_wr = 1; c.ir_load = 1; c.srcb = 2'd1; c.alu = 3'b010; return c;
  endfunction
  function automatic ctl_t c_decode();
    ctl_t c = '0; c.srcb = 2'd3; c.alu = 3'b010; return c;
  endfunction
  function automatic ctl_t c_maddr();
    ctl_t c = '0; c.srca_sel = 1; c.srcb = 2'd2; c.alu = 3'b010; return c;
  endfunction
  function automatic ctl_t c_mrd(); ctl_t c = '0; c.addr_sel = 1; return c; endfunction
  function automatic ctl_t c_mwb();
    ctl_t c = '0; c.rf_we = 1; c.wb_sel = 1; return c;
  endfunction
  function automatic ctl_t c_mwr();
    ctl_t c = '0; c.addr_sel = 1; c.mem_we = 1; return c;
  endfunction
  function automatic ctl_t c_rexec(logic [2:0] op);
    ctl_t c = '0; c.srca_sel = 1; c.alu = op; return c;
  endfunction
  function automatic ctl_t c_rwb();
    ctl_t c = '0; c.rf_we = 1; c.dst_sel = 1; c.addr_sel = 1; return c;
  endfunction
  function automatic ctl_t c_peek(); ctl_t c = '0; c.addr_sel = 1; return c; endfunction
  function automatic ctl_t c_beq();
    ctl_t c = '0; c.srca_sel = 1; c.alu = 3'b110; c.pc_wr_cond = 1; c.pc_src = 2'd1; return c;
  endfunction
  function automatic ctl_t c_jmp();
    ctl_t c = '0; c.pc_wr = 1; c.pc_src = 2'd2; return c;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[0]  = 32'h8C020080; // load r2 <- [0x80]
    mem[1]  = 32'h8C030084; // load r3 <- [0x84]
    mem[2]  = 32'h00432820; // r5 = r2 + r3
    mem[3]  = 32'hAC050088; // store r5 -> [0x88]
    mem[4]  = 32'h10430003; // branch r2==r3 (not taken)
    mem[5]  = 32'h10420002; // branch r2==r2 (taken to 0x20)
    mem[8]  = 32'h08000010; // jump to 0x40
    mem[16] = 32'h0062302A; // r6 = (r3 < r2)
    mem[17] = 32'h00420020; // r0 = r2 + r2 (discarded)
    mem[18] = 32'hAC00008C; // store r0 -> [0x8C]
    mem[32] = 32'h00000005;
    mem[33] = 32'hFFFFFFF9;
    mem[35] = 32'hDEADBEEF;
    {pc_wr, pc_wr_cond, ir_load, addr_sel, srca_sel, rf_we, dst_sel, wb_sel, mem_we} = '0;
    srcb_sel = '0; pc_src = '0; alu_op = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(c_idle(),   ex("R1", 4'b0111, 32'h0, 32'h0, 6'h00, 0));
    // load r2
    step(c_fetch(),  ex("R2", 4'b1001, 32'h0, 0, 0, 1'b0));
    step(c_decode(), ex("R6", 4'b0101, 32'h4, 0, 6'h23, 0));
    step(c_maddr(),  ex("R11", 4'b0010, 0, 32'h0, 0, 0));
    step(c_mrd(),    ex("R7", 4'b0101, 32'h80, 0, 6'h23, 0));
    step(c_mwb(),    none());
    // load r3, write-back collides with operand read of r3
    step(c_fetch(),  ex("R5", 4'b0001, 32'h4, 0, 0, 0));
    step(c_decode(), none());
    step(c_maddr(),  none());
    step(c_mrd(),    ex("R2", 4'b0001, 32'h84, 0, 0, 0));
    step(c_mwb(),    none());
    step(c_fetch(),  ex("R10", 4'b0010, 0, 32'h0, 0, 0));
    step(c_decode(), ex("R10", 4'b0110, 0, 32'hFFFFFFF9, 6'h00, 0));
    // add r5
    step(c_rexec(3'b010), ex("R4", 4'b1000, 0, 0, 0, 1'b0));
    step(c_rwb(),    ex("R4", 4'b0001, 32'hFFFFFFFE, 0, 0, 0));
    // store r5
    step(c_fetch(),  ex("R5", 4'b0001, 32'hC, 0, 0, 0));
    step(c_decode(), none());
    step(c_maddr(),  none());
    step(c_mwr(),    ex("R8", 4'b0011, 32'h88, 32'hFFFFFFFE, 0, 0));
    // branch not taken
    step(c_fetch(),  none());
    step(c_decode(), none());
    step(c_beq(),    ex("R5", 4'b1000, 0, 0, 0, 1'b0));
    step(c_fetch(),  ex("R5", 4'b0001, 32'h14, 0, 0, 0));
    // branch taken: target from shifted immediate
    step(c_decode(), none());
    step(c_beq(),    ex("R4", 4'b1000, 0, 0, 0, 1'b1));
    step(c_fetch(),  ex("R3", 4'b0001, 32'h20, 0, 0, 0));
    // jump
    step(c_decode(), ex("R7", 4'b0100, 0, 0, 6'h02, 0));
    step(c_jmp(),    none());
    step(c_fetch(),  ex("R6", 4'b0001, 32'h40, 0, 0, 0));
    // set-less-than and ALU sweep on A=-7, B=5
    step(c_decode(), none());
    step(c_rexec(3'b111), none());
    step(c_rwb(),    ex("R4", 4'b0001, 32'h1, 0, 0, 0));
    step(c_rexec(3'b000), none());
    step(c_peek(),   ex("R4", 4'b0001, 32'h1, 0, 0, 0));
    step(c_rexec(3'b001), none());
    step(c_peek(),   ex("R4", 4'b0001, 32'hFFFFFFFD, 0, 0, 0));
    step(c_rexec(3'b110), ex("R4", 4'b1000, 0, 0, 0, 1'b0));
    step(c_peek(),   ex("R4", 4'b0001, 32'hFFFFFFF4, 0, 0, 0));
    // write to register 0 is discarded
    step(c_fetch(),  ex("R5", 4'b0001, 32'h44, 0, 0, 0));
    step(c_decode(), none());
    step(c_rexec(3'b010), none());
    step(c_rwb(),    ex("R8", 4'b0001, 32'hA, 0, 0, 0));
    step(c_fetch(),  none());
    step(c_decode(), none());
    step(c_maddr(),  none());
    step(c_mwr(),    ex("R9", 4'b0011, 32'h8C, 32'h0, 0, 0));
    step(c_idle(),   none());
    repeat (3) @(negedge clk);
    #1;
    check("R8", "mem[0x88]", mem[34], 32'hFFFFFFFE);
    check("R9", "mem[0x8C]", mem[35], 32'h0);
    finish_run();
  end

endmodule